// File: doc/BRIEF.md
# Receive Character Queue with Fractional Fill Threshold

This block holds received characters between a serial receiver and the software-facing data register. The receiver offers one character per cycle on a push port. A read of the data register pops the oldest character. The head character is always visible on the read-data output, so a read returns the head in the same cycle that it pops it.

Two control inputs set the buffering behaviour. A queue-enable input selects the working capacity. When it is set, the full storage depth is in use. When it is clear, the queue acts as a single holding slot. A 3-bit level code picks a fraction of the working capacity, in eighths. A request output rises once the fill count reaches that fraction. The comparison is exact, so fractional thresholds are never rounded.

Characters are admitted only while both the port-enable input and the receive-enable input are set. A character offered to a full queue is discarded, and the loss is flagged by a one-cycle pulse.

Top module: `rxq_thresh_fifo`

## Requirements
- R1: After reset the outputs are as follows: `count` is 0, `empty` is 1, `full` is 0, `thresh_hit` is 0 and `overrun` is 0.
- R2: The working capacity depends on `fifo_on`. It is DEPTH when `fifo_on` is 1 and 1 when `fifo_on` is 0. `full` is 1 whenever `count` is at least the working capacity.
- R3: `lvl_sel` codes 0, 1, 2, 3 and 4 select a fraction of 1/8, 2/8, 4/8, 6/8 and 7/8 of the working capacity. `thresh_hit` is 1 exactly when `count`×8 ≥ fraction-in-eighths × working capacity. A new code takes effect from the cycle after the one in which it is presented.
- R4: `lvl_sel` codes 5, 6 and 7 have no effect: the previously selected fraction is kept.
- R5: Out of reset the selected fraction is 4/8 (half), even while an invalid code is presented.
- R6: A push is accepted only when `push_valid`, `port_en` and `rx_en` are all 1 and `full` is 0. With either enable at 0, a push changes nothing and raises no `overrun`.
- R7: Characters leave in the order they were accepted. `pop_data` shows the oldest stored character. A `pop` while not empty removes that character at the clock edge.
- R8: A `pop` while `empty` is 1 is allowed and changes neither `count` nor any flag.
- R9: A push offered with both enables at 1 while `full` is 1 is discarded. `overrun` is then 1 for exactly the following cycle.
- R10: An accepted push and a `pop` in the same cycle, on a non-empty queue, leave `count` unchanged.
- R11: `empty` is 1 exactly when `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_on | input | 1 | 1: full storage depth in use; 0: single-slot mode |
| lvl_sel | input | 3 | Threshold fraction code |
| port_en | input | 1 | Port enable from the control register |
| rx_en | input | 1 | Receive enable from the control register |
| push_valid | input | 1 | Receiver offers a character this cycle |
| push_data | input | DATA_W | Offered character |
| pop | input | 1 | Data register read; removes the head when not empty |
| pop_data | output | DATA_W | Head character |
| count | output | $clog2(DEPTH+1) | Stored character count |
| empty | output | 1 | Queue holds nothing |
| full | output | 1 | Count has reached the working capacity |
| thresh_hit | output | 1 | Count has reached the selected fraction |
| overrun | output | 1 | One-cycle pulse after a discarded push |

## Verification
A corrupted read or write pointer shows up on `pop_data`: the first pop after the fault returns a character out of order or a stale one. A drifting count shows up in the cycle after the faulty edge, as a mismatch on `count`, `empty` or `full`. A lost or mis-held fraction register is only visible when `count` crosses the affected threshold. For that reason the bench steps the count through every level, with each code and with invalid codes in between. Overrun errors appear one cycle after the offending push into a full queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        LVL_EIGHTH  = 3'd0,
        LVL_QUARTER = 3'd1,
        LVL_HALF    = 3'd2,
        LVL_THREEQ  = 3'd3,
        LVL_SEVENE  = 3'd4
    } lvl_code_e;

    localparam int EIGHTHS_W = 4;

    // Fraction of the working capacity in eighths; 0 marks an invalid code.
    function automatic logic [EIGHTHS_W-1:0] lvl_to_eighths(input logic [2:0] code);
        case (code)
            LVL_EIGHTH:  return 4'd1;
            LVL_QUARTER: return 4'd2;
            LVL_HALF:    return 4'd4;
            LVL_THREEQ:  return 4'd6;
            LVL_SEVENE:  return 4'd7;
            default:     return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/rxq_slots.sv
module rxq_slots #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DATA_W-1:0] slot_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_en && (wr_idx == PTR_W'(i))) begin
                slot_d[i] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on,
    input  logic             port_en,
    input  logic             rx_en,
    input  logic             push_valid,
    input  logic             pop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             overrun
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [CNT_W-1:0] act_depth;
    logic             rx_open;
    logic             take;
    logic             drop;
    logic             give;

    always_comb begin
        act_depth = fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);
        rx_open   = port_en && rx_en;
        full      = (st_q.cnt >= act_depth);
        empty     = (st_q.cnt == '0);
        take      = push_valid && rx_open && !full;
        drop      = push_valid && rx_open && full;
        give      = pop && !empty;

        st_d     = st_q;
        st_d.ovr = drop;
        if (take) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_IDX) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (give) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_IDX) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({take, give})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = take;
    assign wr_idx  = st_q.wr_ptr;
    assign rd_idx  = st_q.rd_ptr;
    assign count   = st_q.cnt;
    assign overrun = st_q.ovr;

endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on,
    input  logic [2:0]       lvl_sel,
    input  logic [CNT_W-1:0] count,
    output logic             thresh_hit
);
    import rxq_pkg::*;

    localparam int CMP_W = CNT_W + EIGHTHS_W + 1;

    typedef struct packed {
        logic [EIGHTHS_W-1:0] eighths;
    } lvl_t;

    lvl_t st_d, st_q;

    logic [EIGHTHS_W-1:0] cand;
    logic [CMP_W-1:0]     lhs;
    logic [CMP_W-1:0]     rhs;
    logic [CMP_W-1:0]     act_depth;

    always_comb begin
        cand = lvl_to_eighths(lvl_sel);
        st_d = st_q;
        if (cand != '0) begin
            st_d.eighths = cand;
        end

        act_depth  = fifo_on ? CMP_W'(DEPTH) : CMP_W'(1);
        lhs        = CMP_W'(count) << 3;
        rhs        = CMP_W'(st_q.eighths) * act_depth;
        thresh_hit = (lhs >= rhs);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.eighths <= lvl_to_eighths(LVL_HALF);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxq_thresh_fifo.sv
module rxq_thresh_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_on,
    input  logic [2:0]        lvl_sel,
    input  logic              port_en,
    input  logic              rx_en,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              thresh_hit,
    output logic              overrun
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;

    rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_on    (fifo_on),
        .port_en    (port_en),
        .rx_en      (rx_en),
        .push_valid (push_valid),
        .pop        (pop),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .count      (count),
        .empty      (empty),
        .full       (full),
        .overrun    (overrun)
    );

    rxq_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_idx  (rd_idx),
        .rd_data (pop_data)
    );

    rxq_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_on    (fifo_on),
        .lvl_sel    (lvl_sel),
        .count      (count),
        .thresh_hit (thresh_hit)
    );

endmodule

// File: rtl/rxq_thresh_fifo_chk.sv
module rxq_thresh_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_on,
    input logic             port_en,
    input logic             rx_en,
    input logic             push_valid,
    input logic             pop,
    input logic [CNT_W-1:0] count,
    input logic             empty,
    input logic             full,
    input logic             thresh_hit,
    input logic             overrun
);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r2_single_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && !empty) |-> full);

    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (thresh_hit == !empty));

    a_r6_closed_port: assert property (@(posedge clk) disable iff (!rst_n)
        ((!port_en || !rx_en) && !pop) |=> $stable(count));

    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_valid) |=> (count == '0));

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(full && push_valid && port_en && rx_en));

    a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) - int'($past(count)) <= 1) && (int'($past(count)) - int'(count) <= 1));

    a_r10_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && port_en && rx_en && !full && pop && !empty) |=> $stable(count));

endmodule

bind rxq_thresh_fifo rxq_thresh_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_on    (fifo_on),
    .port_en    (port_en),
    .rx_en      (rx_en),
    .push_valid (push_valid),
    .pop        (pop),
    .count      (count),
    .empty      (empty),
    .full       (full),
    .thresh_hit (thresh_hit),
    .overrun    (overrun)
);

// File: tb/rxq_thresh_fifo_test.sv
module rxq_thresh_fifo_test;

    localparam int DEPTH   = 16;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int CLK_PER = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              fifo_on;
    logic [2:0]        lvl_sel;
    logic              port_en;
    logic              rx_en;
    logic              push_valid;
    logic [DATA_W-1:0] push_data;
    logic              pop;
    logic [DATA_W-1:0] pop_data;
    logic [CNT_W-1:0]  count;
    logic              empty;
    logic              full;
    logic              thresh_hit;
    logic              overrun;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    logic [DATA_W-1:0] mq[$];
    int                m_frac;
    bit                m_ovr;

    always #(CLK_PER/2) clk = ~clk;

    rxq_thresh_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .lvl_sel(lvl_sel),
        .port_en(port_en), .rx_en(rx_en), .push_valid(push_valid),
        .push_data(push_data), .pop(pop), .pop_data(pop_data), .count(count),
        .empty(empty), .full(full), .thresh_hit(thresh_hit), .overrun(overrun)
    );

    function automatic int eighths_of(input int code, input int prev);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 7;
            default: return prev;
        endcase
    endfunction

    function automatic int cap_of(input logic on);
        return on ? DEPTH : 1;
    endfunction

    task automatic check1(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int c;
        int cap;
        c   = mq.size();
        cap = cap_of(fifo_on);
        check1(tag, "count", int'(count), c);
        check1(tag, "empty", int'(empty), int'(c == 0));
        check1(tag, "full", int'(full), int'(c >= cap));
        check1(tag, "thresh_hit", int'(thresh_hit), int'(c * 8 >= m_frac * cap));
        check1(tag, "overrun", int'(overrun), int'(m_ovr));
        if (c > 0) check1(tag, "pop_data", int'(pop_data), int'(mq[0]));
    endtask

    task automatic step(input string tag);
        int  c;
        bit  open;
        bit  isfull;
        c      = mq.size();
        open   = port_en && rx_en;
        isfull = (c >= cap_of(fifo_on));
        m_ovr  = push_valid && open && isfull;
        if (pop && c > 0) void'(mq.pop_front());
        if (push_valid && open && !isfull) mq.push_back(push_data);
        m_frac = eighths_of(int'(lvl_sel), m_frac);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic quiet();
        push_valid = 1'b0;
        pop        = 1'b0;
    endtask

    task automatic push_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            push_valid = 1'b1;
            push_data  = DATA_W'($urandom);
            pop        = 1'b0;
            step(tag);
        end
        quiet();
    endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) begin
            push_valid = 1'b0;
            pop        = 1'b1;
            step(tag);
        end
        quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; fifo_on = 1'b1; lvl_sel = 3'd7; port_en = 1'b1; rx_en = 1'b1;
        push_valid = 1'b0; push_data = '0; pop = 1'b0;
        m_frac = 4; m_ovr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R5: half threshold from reset while an invalid code is held
        push_n(DEPTH / 2 + 1, "R5");
        drain("R7");

        // R3 / R4: pick 1/8, then present an invalid code
        lvl_sel = 3'd0; step("R3");
        lvl_sel = 3'd5; step("R4");
        push_n(2, "R4");
        lvl_sel = 3'd6; push_n(1, "R4");
        lvl_sel = 3'd1; step("R3");
        push_n(2, "R3");
        drain("R7");

        // R8: reading an empty queue
        for (int i = 0; i < 3; i++) begin
            pop = 1'b1; step("R8");
        end
        quiet();

        // R6: closed port accepts nothing and reports nothing
        port_en = 1'b0; push_n(3, "R6");
        port_en = 1'b1; rx_en = 1'b0; push_n(3, "R6");
        rx_en = 1'b1;

        // R9: overflow pulse
        push_n(DEPTH + 2, "R9");
        step("R9");
        port_en = 1'b0; push_n(1, "R9"); port_en = 1'b1;

        // R2: single-slot mode
        fifo_on = 1'b0; step("R2");
        drain("R2");
        push_n(2, "R2");
        step("R2");
        fifo_on = 1'b1; step("R2");
        drain("R2");

        // R10: simultaneous push and pop
        push_n(3, "R10");
        for (int i = 0; i < 4; i++) begin
            push_valid = 1'b1; push_data = DATA_W'($urandom); pop = 1'b1;
            step("R10");
        end
        quiet();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 2)  fifo_on = ~fifo_on;
            if ($urandom_range(0, 99) < 5)  lvl_sel = 3'($urandom_range(0, 7));
            port_en    = ($urandom_range(0, 99) < 95);
            rx_en      = ($urandom_range(0, 99) < 95);
            push_valid = ($urandom_range(0, 99) < 55);
            push_data  = DATA_W'($urandom);
            pop        = ($urandom_range(0, 99) < 45);
            step("R11 R7 R3");
        end
        quiet();
        fifo_on = 1'b1;
        drain("R7");

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule